// File: doc/BRIEF.md
# Six-Channel Paired-Update DAC Code Register Bank

This block sits behind a byte-wide host port and holds the digital codes for six 12-bit digital-to-analog converter channels. The host loads each code in two writes: first the low eight bits, then the upper four bits. Each channel keeps a holding register for the code being assembled and an output register that feeds the converter.

The channels form three fixed pairs, and a static mode bit per pair picks between two commit policies. In transfer mode the high-nibble write commits the code at once. In simultaneous mode the channels wait, and any host read inside the analog window moves every waiting channel's code to its output in the same clock. This lets several axes change together. A separate static zero-start option keeps every output at code 0 with its enable low after reset. The outputs are released only after the host has written some high nibble and then read inside the window.

Top module: `dac6_regbank`

## Requirements
- R1: Channel n (0 to 5) takes its low 8 bits from a write at offset 2n and its upper 4 bits from a write at offset 2n+1. Writes at offsets 12 to 15 change no channel.
- R2: A low-byte write loads the channel's holding register only. The channel output does not change in response to it.
- R3: A high-nibble write takes the upper 4 bits from write data bits 3:0. Data bits 7:4 have no effect on any output.
- R4: For a channel in transfer mode, a high-nibble write places the full 12-bit holding value on the output at the clock edge that samples the strobe. Reads never change a transfer-mode output.
- R5: `pair_sim` bit p sets the mode of channels 2p and 2p+1: 0 selects transfer mode and 1 selects simultaneous mode.
- R6: For a channel in simultaneous mode, writes never change the output. A read at any offset from 0 to 12 copies the holding value to the output at the edge that samples the read. Reads at offsets 13 to 15 do not.
- R7: With `zero_pwrup` high, all six codes read 0 and all enables are low after reset. This holds until a high-nibble write has occurred and a read at offsets 0 to 12 happens in the same cycle or a later one. A read made before any high-nibble write does not release the outputs. Once released, the outputs stay released until reset.
- R8: With `zero_pwrup` low, all enables are high from reset onward and the codes show the output registers directly.
- R9: Reset sets every holding and output register to 0 and clears the release state.
- R10: When a read in the window arrives in the same cycle as a high-nibble write, the update uses the value that write has just captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| pair_sim | input | 3 | Per-pair mode, 1 = simultaneous |
| zero_pwrup | input | 1 | Static zero-start option |
| ch_code | output | 72 | Six 12-bit codes, channel n at bits 12n+11:12n |
| ch_en | output | 6 | Per-channel output enable |

## Verification
Every result in this block is due one clock after its strobe: a transfer commit, a group update and the zero-start release all appear after the rising edge that samples the write or read. A low-byte write, a read at 13 to 15, or any write to a simultaneous pair must leave the outputs unchanged after that same edge. The bench drives each strobe for one cycle from a falling edge. It compares all six codes and enables at the next falling edge, just after the edge that is due to change them. This is done for every pair-mode combination, for both start options, and for a read and a high-nibble write in the same cycle.

// File: rtl/dac6_pkg.sv
package dac6_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned NUM_CH  = 6;
  localparam int unsigned ADDR_W  = 4;
endpackage

// File: rtl/dac6_decode.sv
module dac6_decode #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic              hi_any,
  output logic              rd_win
);
  localparam int unsigned NREG = 2 * NUM_CH;

  always_comb begin
    lo_we = '0;
    hi_we = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (wr && (int'(addr) == 2 * n))     lo_we[n] = 1'b1;
      if (wr && (int'(addr) == 2 * n + 1)) hi_we[n] = 1'b1;
    end
    hi_any = |hi_we;
    // window covers every channel register plus the first port after them
    rd_win = rd && (int'(addr) <= NREG);
  end
endmodule

// File: rtl/dac6_chan.sv
module dac6_chan #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              xfer_mode,
  input  logic              grp_upd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CODE_W-1:0] code_q
);
  localparam int unsigned HI_W = CODE_W - BUS_W;

  logic [BUS_W-1:0]  lo_q, lo_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [CODE_W-1:0] code_n;
  logic              commit;

  always_comb begin
    lo_n   = lo_we ? wdata : lo_q;
    hi_n   = hi_we ? wdata[HI_W-1:0] : hi_q;
    commit = xfer_mode ? hi_we : grp_upd;
    code_n = commit ? {hi_n, lo_n} : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      code_q <= '0;
    end else begin
      if (lo_we)  lo_q   <= lo_n;
      if (hi_we)  hi_q   <= hi_n;
      if (commit) code_q <= code_n;
    end
  end

  // R2: a low-byte write alone leaves the output as it was
  a_r2_lo_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !(grp_upd && !xfer_mode)) |=> $stable(code_q));

  // R4: transfer-mode high write lands its nibble on the output next cycle
  a_r4_xfer_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && xfer_mode) |=> (code_q[CODE_W-1:BUS_W] == $past(wdata[HI_W-1:0])));

  // R6: simultaneous-mode output holds without a group update
  a_r6_sim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_mode && !grp_upd) |=> $stable(code_q));

  // R10: update coinciding with a high write uses the fresh nibble
  a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && grp_upd && !xfer_mode) |=> (code_q[CODE_W-1:BUS_W] == $past(wdata[HI_W-1:0])));
endmodule

// File: rtl/dac6_zero_gate.sv
module dac6_zero_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_mode,
  input  logic hi_any,
  input  logic rd_win,
  output logic out_en
);
  logic seen_q, seen_n;
  logic rel_q, rel_n;

  always_comb begin
    seen_n = seen_q | hi_any;
    rel_n  = rel_q | (rd_win & seen_n);
    out_en = !zero_mode | rel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      seen_q <= seen_n;
      rel_q  <= rel_n;
    end
  end

  // R7: release only follows a read in the window
  a_r7_rel_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(rd_win));

  // R7: once released, stays released
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> rel_q);

  // R8: standard start keeps the enable high
  a_r8_std_en: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_mode |-> out_en);
endmodule

// File: rtl/dac6_regbank.sv
module dac6_regbank
  import dac6_pkg::*;
#(
  parameter int unsigned P_BUS_W  = BUS_W,
  parameter int unsigned P_CODE_W = CODE_W,
  parameter int unsigned P_NUM_CH = NUM_CH,
  parameter int unsigned P_ADDR_W = ADDR_W,
  localparam int unsigned NPAIR   = P_NUM_CH / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [P_ADDR_W-1:0]          bus_addr,
  input  logic [P_BUS_W-1:0]           bus_wdata,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [NPAIR-1:0]             pair_sim,
  input  logic                         zero_pwrup,
  output logic [P_NUM_CH*P_CODE_W-1:0] ch_code,
  output logic [P_NUM_CH-1:0]          ch_en
);
  logic [P_NUM_CH-1:0] lo_we, hi_we;
  logic                hi_any, rd_win, out_en;

  dac6_decode #(.NUM_CH(P_NUM_CH), .ADDR_W(P_ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .lo_we(lo_we), .hi_we(hi_we), .hi_any(hi_any), .rd_win(rd_win)
  );

  dac6_zero_gate u_gate (
    .clk(clk), .rst_n(rst_n), .zero_mode(zero_pwrup),
    .hi_any(hi_any), .rd_win(rd_win), .out_en(out_en)
  );

  for (genvar n = 0; n < P_NUM_CH; n++) begin : g_ch
    logic [P_CODE_W-1:0] code_q;

    dac6_chan #(.BUS_W(P_BUS_W), .CODE_W(P_CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .lo_we(lo_we[n]), .hi_we(hi_we[n]),
      .xfer_mode(!pair_sim[n/2]), .grp_upd(rd_win),
      .wdata(bus_wdata), .code_q(code_q)
    );

    assign ch_code[n*P_CODE_W +: P_CODE_W] = out_en ? code_q : '0;
    assign ch_en[n] = out_en;
  end
endmodule

// File: tb/dac6_regbank_test.sv
`timescale 1ns/1ps
module dac6_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [2:0]  pair_sim;
  logic        zero_pwrup;
  logic [71:0] ch_code;
  logic [5:0]  ch_en;

  int checks = 0;
  int failures = 0;

  logic [7:0]  m_lo [6];
  logic [3:0]  m_hi [6];
  logic [11:0] m_out [6];
  logic        m_seen, m_rel;

  dac6_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .pair_sim(pair_sim),
    .zero_pwrup(zero_pwrup), .ch_code(ch_code), .ch_en(ch_en)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag);
    logic [71:0] ec;
    logic [5:0]  ee;
    for (int c = 0; c < 6; c++) begin
      ec[c*12 +: 12] = (zero_pwrup && !m_rel) ? 12'h000 : m_out[c];
      ee[c] = !zero_pwrup || m_rel;
    end
    checks++;
    if (ch_code !== ec || ch_en !== ee) begin
      failures++;
      $display("FAIL %s code=%h en=%b expected code=%h en=%b", tag, ch_code, ch_en, ec, ee);
    end
  endtask

  task automatic do_reset(input logic [2:0] cfg, input logic zm);
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pair_sim = cfg; zero_pwrup = zm;
    for (int c = 0; c < 6; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_out[c] = '0; end
    m_seen = 1'b0; m_rel = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one bus cycle; model updates from the requirements
  task automatic bus(input logic [3:0] a, input logic [7:0] d, input logic w, input logic r);
    int ch;
    ch = int'(a) / 2;
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (w && a < 4'd12) begin
      if (!a[0]) m_lo[ch] = d;
      else begin
        m_hi[ch] = d[3:0];
        m_seen = 1'b1;
        if (!pair_sim[ch/2]) m_out[ch] = {m_hi[ch], m_lo[ch]};
      end
    end
    if (r && a <= 4'd12) begin
      for (int c = 0; c < 6; c++)
        if (pair_sim[c/2]) m_out[c] = {m_hi[c], m_lo[c]};
      if (m_seen) m_rel = 1'b1;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pair_sim = '0; zero_pwrup = 1'b0;

    // sweep every pair-mode combination in standard start
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[2:0], 1'b0);
      chk("R9 R8 reset state");
      for (int rnd = 0; rnd < 2; rnd++) begin
        for (int c = 0; c < 6; c++) begin
          bus(4'(2*c), 8'((c*37 + cfg*11 + rnd*91) & 255), 1'b1, 1'b0);
          chk("R1 R2 low byte write");
          bus(4'(2*c+1), 8'(8'hA0 | ((c + cfg + rnd*7) & 15)), 1'b1, 1'b0);
          chk("R3 R4 R5 R6 high nibble write");
        end
        for (int a = 12; a < 16; a++) begin
          bus(4'(a), 8'hFF, 1'b1, 1'b0);
          chk("R1 write outside channels");
        end
        bus(4'd13, 8'h00, 1'b0, 1'b1);
        chk("R6 read at 13 no update");
        bus(4'd15, 8'h00, 1'b0, 1'b1);
        chk("R6 read at 15 no update");
        bus(4'((rnd == 0) ? 12 : cfg), 8'h00, 1'b0, 1'b1);
        chk("R6 R4 read in window");
      end
    end

    // same-cycle read and high write, all simultaneous
    do_reset(3'b111, 1'b0);
    bus(4'd4, 8'h5C, 1'b1, 1'b0);
    bus(4'd5, 8'hF9, 1'b1, 1'b1);
    chk("R10 same cycle update");
    bus(4'd2, 8'h11, 1'b1, 1'b0);
    bus(4'd3, 8'h02, 1'b1, 1'b1);
    chk("R10 same cycle other channel");

    // zero start: read before any high write does not release
    do_reset(3'b010, 1'b1);
    chk("R7 zero after reset");
    bus(4'd0, 8'h00, 1'b0, 1'b1);
    chk("R7 early read no release");
    bus(4'd0, 8'h34, 1'b1, 1'b0);
    bus(4'd1, 8'h02, 1'b1, 1'b0);
    chk("R7 write alone no release");
    bus(4'd2, 8'h77, 1'b1, 1'b0);
    bus(4'd3, 8'h05, 1'b1, 1'b0);
    bus(4'd14, 8'h00, 1'b0, 1'b1);
    chk("R7 read outside window no release");
    bus(4'd12, 8'h00, 1'b0, 1'b1);
    chk("R7 release after read");
    bus(4'd11, 8'h0F, 1'b1, 1'b0);
    chk("R7 stays released");

    // zero start released by read coinciding with the first high write
    do_reset(3'b000, 1'b1);
    bus(4'd6, 8'hAB, 1'b1, 1'b0);
    bus(4'd7, 8'h03, 1'b1, 1'b1);
    chk("R7 R10 release same cycle");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule